// File: doc/BRIEF.md
# HDLC Frame Receiver

This block recovers bit-oriented HDLC frames from a serial line. A one-bit input, qualified by a strobe, is scanned for the opening flag at every bit position, not on byte boundaries. Between flags the block removes the zero that follows five ones, packs the remaining bits into bytes (least significant bit first), runs the CCITT CRC-16 over the data and the frame check sequence, and can drop frames whose first byte does not match a programmed address.

Each delivered byte appears on a one-cycle strobe, and the first byte of a frame carries a start marker. The two check bytes are held back and never delivered. Every frame that is not dropped ends with a one-cycle end-of-frame pulse that carries a two-bit verdict. Flags never reach the byte output. A separate pulse reports a go-ahead pattern on the line. Storage, register access and interrupts are left to the surrounding logic.

Top module: `hdlc_rx`

## Requirements
- R1: After reset, and after an abort, the block is out of sync. Bits on the line are ignored until a flag (0, six 1s, 0) completes at any bit alignment. That flag opens a frame.
- R2: Flag bits never reach the byte output. Several flags in a row, and a single flag that closes one frame and opens the next, produce no empty frame and no end-of-frame pulse.
- R3: Inside a frame, a 0 that follows five consecutive 1s is deleted and does not count as data.
- R4: Bytes are assembled least significant bit first. The last two bytes before the closing flag are the check sequence and are not delivered. `byte_sof` is high with the first delivered byte of a frame and low with every other byte.
- R5: At the closing flag, a frame of at least four bytes reports status 0 (good) when its bit count is a multiple of eight and the CRC (reflected polynomial 0x8408, preset 0xFFFF, run over data and check bytes) ends at 0xF0B8. Otherwise it reports status 1 (bad check).
- R6: A frame with at least one bit but fewer than four whole bytes between its flags (a data field under 16 bits) reports status 3 (too short).
- R7: When `addr_en` is 1 and the first byte differs from `addr_val`, the frame delivers no bytes and no end-of-frame pulse. When `addr_en` is 0, every frame is delivered.
- R8: Seven consecutive 1s inside a frame that holds at least one data bit give an end-of-frame pulse with status 2 (aborted). The block then returns to flag hunting. Seven 1s right after a flag report nothing.
- R9: `goahead` pulses for one cycle when the last eight line bits are a 0 followed by seven 1s. A plain flag does not trigger it.
- R10: When `bit_valid` is 0, `bit_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_valid | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial line bit |
| addr_en | input | 1 | Enables first-byte address filtering |
| addr_val | input | 8 | Address that frames must match |
| byte_valid | output | 1 | One-cycle strobe for a delivered byte |
| byte_data | output | 8 | Delivered byte |
| byte_sof | output | 1 | Marks the first byte of a frame |
| frame_done | output | 1 | End-of-frame pulse |
| frame_status | output | 2 | Verdict: 0 good, 1 bad check, 2 aborted, 3 too short |
| goahead | output | 1 | Go-ahead pattern seen |

## Verification
The assertions rely on the line-code events being mutually exclusive per bit and on flag and abort events never sharing a cycle with a delivered bit. Both follow from one serial bit arriving per strobe. They also assume that `addr_en` and `addr_val` stay steady for the length of a frame, so the stimulus changes them only while the line sits between frames. The stimulus drives complete bit sequences through tasks, one bit per strobe with optional idle gaps. The address inputs are changed only before an opening flag.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  typedef enum logic [1:0] {
    ST_GOOD   = 2'd0,
    ST_BADFCS = 2'd1,
    ST_ABORT  = 2'd2,
    ST_SHORT  = 2'd3
  } frame_stat_e;

  localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_RF = 16'h8408;
  localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;

  // one serial bit through the reflected CCITT register
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return (c >> 1) ^ (fb ? CRC_POLY_RF : 16'h0000);
  endfunction

  // verdict at the closing flag: length first, then alignment, then residue
  function automatic frame_stat_e frame_verdict(input logic long_ok,
                                                input logic aligned,
                                                input logic [15:0] crc);
    if (!long_ok) return ST_SHORT;
    if (!aligned) return ST_BADFCS;
    if (crc != CRC_RESIDUE) return ST_BADFCS;
    return ST_GOOD;
  endfunction

endpackage

// File: rtl/hdlc_rx_linecode.sv
module hdlc_rx_linecode #(
  parameter int STUFF_RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_in,
  output logic ev_flag,
  output logic ev_abort,
  output logic ev_stuff,
  output logic ev_data,
  output logic data_bit,
  output logic ev_goahead
);
  localparam int FLAG_RUN  = STUFF_RUN + 1;
  localparam int ABORT_RUN = STUFF_RUN + 2;
  localparam int CW        = $clog2(ABORT_RUN + 1);
  localparam int HW        = ABORT_RUN + 1;
  localparam logic [CW-1:0] K_STUFF = CW'(STUFF_RUN);
  localparam logic [CW-1:0] K_FLAG  = CW'(FLAG_RUN);
  localparam logic [CW-1:0] K_ABORT = CW'(ABORT_RUN);
  localparam logic [HW-1:0] GA_PAT  = {{ABORT_RUN{1'b1}}, 1'b0};

  logic [CW-1:0] ones_q;
  logic [HW-1:0] hist_q, hist_nx;

  always_comb begin
    hist_nx    = {bit_in, hist_q[HW-1:1]};
    ev_flag    = bit_valid && !bit_in && (ones_q == K_FLAG);
    ev_stuff   = bit_valid && !bit_in && (ones_q == K_STUFF);
    ev_abort   = bit_valid &&  bit_in && (ones_q == K_FLAG);
    ev_data    = bit_valid && (bit_in ? (ones_q < K_STUFF)
                                      : ((ones_q < K_STUFF) || (ones_q == K_ABORT)));
    data_bit   = bit_in;
    ev_goahead = bit_valid && (hist_nx == GA_PAT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
      hist_q <= '1;
    end else if (bit_valid) begin
      hist_q <= hist_nx;
      if (!bit_in)                ones_q <= '0;
      else if (ones_q != K_ABORT) ones_q <= ones_q + 1'b1;
    end
  end

  AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_flag, ev_abort, ev_stuff, ev_data})); // R3

  AST_STUFF_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stuff |-> (hist_q[HW-1 -: STUFF_RUN] == '1)); // R3

endmodule

// File: rtl/hdlc_rx_holdback.sv
module hdlc_rx_holdback #(
  parameter int DEPTH = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic push_bit,
  input  logic clear,
  output logic pop_valid,
  output logic pop_bit,
  output logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int FW = $clog2(DEPTH + 1);
  localparam logic [FW-1:0] K_FULL = FW'(DEPTH);

  logic [DEPTH-1:0] sr_q;
  logic [FW-1:0]    fill_q;

  assign pop_valid = push && !clear && (fill_q == K_FULL);
  assign pop_bit   = sr_q[0];
  assign fill      = fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      fill_q <= '0;
    end else if (clear) begin
      fill_q <= '0;
    end else if (push) begin
      sr_q <= {push_bit, sr_q[DEPTH-1:1]};
      if (fill_q != K_FULL) fill_q <= fill_q + 1'b1;
    end
  end

endmodule

// File: rtl/hdlc_rx_framer.sv
module hdlc_rx_framer
  import hdlc_rx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int MIN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_ev,
  input  logic              abort_ev,
  input  logic              pop_valid,
  input  logic              pop_bit,
  input  logic              addr_en,
  input  logic [BYTE_W-1:0] addr_val,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_sof,
  output logic              frame_done,
  output logic [1:0]        frame_status,
  output logic              in_frame
);
  localparam int PW = $clog2(BYTE_W);
  localparam int NW = $clog2(MIN_BYTES + 1);
  localparam logic [PW-1:0] K_LAST = PW'(BYTE_W - 1);
  localparam logic [NW-1:0] K_MIN  = NW'(MIN_BYTES);
  localparam logic [NW-1:0] K_HOLD = NW'(2);

  logic              in_frame_q, drop_q;
  logic [PW-1:0]     phase_q;
  logic [NW-1:0]     nbytes_q;
  logic [BYTE_W-1:0] sh_q, sh_nx, hold_old_q, hold_new_q;
  logic [15:0]       crc_q;
  frame_stat_e       stat_q;
  logic              has_bits, byte_end;

  assign sh_nx        = {pop_bit, sh_q[BYTE_W-1:1]};
  assign has_bits     = (nbytes_q != '0) || (phase_q != '0);
  assign byte_end     = (phase_q == K_LAST);
  assign in_frame     = in_frame_q;
  assign frame_status = stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      drop_q     <= 1'b0;
      phase_q    <= '0;
      nbytes_q   <= '0;
      sh_q       <= '0;
      hold_old_q <= '0;
      hold_new_q <= '0;
      crc_q      <= CRC_PRESET;
      stat_q     <= ST_GOOD;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      byte_sof   <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      byte_sof   <= 1'b0;
      frame_done <= 1'b0;
      if (flag_ev || abort_ev) begin
        if (in_frame_q && has_bits && !drop_q) begin
          frame_done <= 1'b1;
          stat_q     <= abort_ev ? ST_ABORT
                                 : frame_verdict(nbytes_q == K_MIN, phase_q == '0, crc_q);
        end
        in_frame_q <= flag_ev;
        drop_q     <= 1'b0;
        phase_q    <= '0;
        nbytes_q   <= '0;
        crc_q      <= CRC_PRESET;
      end else if (pop_valid && in_frame_q) begin
        crc_q   <= crc_step(crc_q, pop_bit);
        sh_q    <= sh_nx;
        phase_q <= phase_q + 1'b1;
        if (byte_end) begin
          hold_new_q <= sh_nx;
          hold_old_q <= hold_new_q;
          if (nbytes_q == '0) drop_q <= addr_en && (sh_nx != addr_val);
          if ((nbytes_q >= K_HOLD) && !drop_q) begin
            byte_valid <= 1'b1;
            byte_data  <= hold_old_q;
            byte_sof   <= (nbytes_q == K_HOLD);
          end
          if (nbytes_q != K_MIN) nbytes_q <= nbytes_q + 1'b1;
        end
      end
    end
  end

  AST_BYTE_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(in_frame_q)); // R1

  AST_DROPPED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    drop_q |-> !byte_valid); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R5

endmodule

// File: rtl/hdlc_rx.sv
module hdlc_rx #(
  parameter int BYTE_W    = 8,
  parameter int STUFF_RUN = 5,
  parameter int MIN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  input  logic              bit_in,
  input  logic              addr_en,
  input  logic [BYTE_W-1:0] addr_val,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_sof,
  output logic              frame_done,
  output logic [1:0]        frame_status,
  output logic              goahead
);
  localparam int HOLD = STUFF_RUN + 1;
  localparam int FW   = $clog2(HOLD + 1);

  logic ev_flag, ev_abort, ev_stuff, ev_data, data_bit, ev_goahead;
  logic pop_valid, pop_bit, in_frame;
  logic [FW-1:0] dly_fill;

  hdlc_rx_linecode #(.STUFF_RUN(STUFF_RUN)) u_line (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .ev_flag(ev_flag), .ev_abort(ev_abort), .ev_stuff(ev_stuff),
    .ev_data(ev_data), .data_bit(data_bit), .ev_goahead(ev_goahead));

  hdlc_rx_holdback #(.DEPTH(HOLD)) u_hold (
    .clk(clk), .rst_n(rst_n), .push(ev_data), .push_bit(data_bit),
    .clear(ev_flag || ev_abort), .pop_valid(pop_valid), .pop_bit(pop_bit),
    .fill(dly_fill));

  hdlc_rx_framer #(.BYTE_W(BYTE_W), .MIN_BYTES(MIN_BYTES)) u_frm (
    .clk(clk), .rst_n(rst_n), .flag_ev(ev_flag), .abort_ev(ev_abort),
    .pop_valid(pop_valid), .pop_bit(pop_bit), .addr_en(addr_en),
    .addr_val(addr_val), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_sof(byte_sof), .frame_done(frame_done), .frame_status(frame_status),
    .in_frame(in_frame));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) goahead <= 1'b0;
    else        goahead <= ev_goahead;
  end

  AST_FLAG_EMPTIES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flag |=> (dly_fill == '0)); // R2

  AST_NO_POP_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_flag || ev_abort) |-> !pop_valid); // R2

endmodule

// File: tb/tb_hdlc_rx.sv
module tb_hdlc_rx;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, bit_valid, bit_in, addr_en;
  logic [7:0] addr_val;
  logic       byte_valid, byte_sof, frame_done, goahead;
  logic [7:0] byte_data;
  logic [1:0] frame_status;

  hdlc_rx dut (.clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .addr_en(addr_en), .addr_val(addr_val), .byte_valid(byte_valid),
    .byte_data(byte_data), .byte_sof(byte_sof), .frame_done(frame_done),
    .frame_status(frame_status), .goahead(goahead));

  int n_tests = 0, n_fail = 0;
  logic [7:0] got_q[$];
  logic       sof_q[$];
  int done_cnt = 0, ga_cnt = 0;
  logic [1:0] last_stat = 2'd0;
  logic [7:0] fb[0:15];
  int tx_ones = 0;
  bit gap = 0;

  always @(negedge clk) if (rst_n) begin
    if (byte_valid) begin got_q.push_back(byte_data); sof_q.push_back(byte_sof); end
    if (frame_done) begin done_cnt++; last_stat = frame_status; end
    if (goahead) ga_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    got_q.delete(); sof_q.delete(); done_cnt = 0; ga_cnt = 0;
  endtask

  task automatic put_raw(input logic b);
    @(negedge clk); bit_valid = 1'b1; bit_in = b;
    if (gap) begin @(negedge clk); bit_valid = 1'b0; bit_in = ~b; end
  endtask

  task automatic idle(input int n);
    @(negedge clk); bit_valid = 1'b0;
    for (int i = 0; i < n; i++) begin @(negedge clk); bit_in = ~bit_in; end
  endtask

  task automatic put_data(input logic b);
    put_raw(b);
    tx_ones = b ? tx_ones + 1 : 0;
    if (tx_ones == 5) begin put_raw(1'b0); tx_ones = 0; end
  endtask

  task automatic put_flag();
    put_raw(1'b0);
    for (int i = 0; i < 6; i++) put_raw(1'b1);
    put_raw(1'b0);
    tx_ones = 0;
  endtask

  task automatic put_ones(input int n);
    for (int i = 0; i < n; i++) put_raw(1'b1);
    tx_ones = 0;
  endtask

  task automatic put_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) put_data(v[i]);
  endtask

  function automatic logic [15:0] fcs_of(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {8'h00, fb[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic send_frame(input int n, input bit open, input bit corrupt, input int extra);
    logic [15:0] f;
    if (open) put_flag();
    for (int i = 0; i < n; i++) put_byte(fb[i]);
    f = fcs_of(n);
    if (corrupt) f = f ^ 16'h0001;
    put_byte(f[7:0]);
    put_byte(f[15:8]);
    for (int i = 0; i < extra; i++) put_data(i[0]);
    put_flag();
    idle(4);
  endtask

  task automatic check_bytes(input int n, input string req);
    int bad = 0;
    if (got_q.size() != n) bad = 1;
    else for (int i = 0; i < n; i++)
      if (got_q[i] !== fb[i] || sof_q[i] !== (i == 0)) bad++;
    chk(bad == 0, req, got_q.size(), n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_valid = 1'b0; bit_in = 1'b0; addr_en = 1'b0; addr_val = 8'h00;
    repeat (3) @(negedge clk);
    chk(byte_valid == 0 && frame_done == 0 && goahead == 0, "R1 reset", byte_valid, 0);
    rst_n = 1'b1;

    // R10: strobe low, line toggling
    clear_mon(); idle(20);
    chk(done_cnt == 0 && got_q.size() == 0, "R10 idle line", done_cnt, 0);

    // R1 R3 R4 R5: sweep alignment, length and idle gaps
    for (int pre = 0; pre < 8; pre++) begin
      for (int n = 2; n < 6; n++) begin
        gap = pre[0];
        for (int i = 0; i < n; i++) fb[i] = 8'(8'hFF ^ (i * pre * 13));
        fb[1] = 8'hFF;
        clear_mon();
        put_ones(8);
        for (int i = 0; i < pre; i++) put_raw(i[0]);
        send_frame(n, 1'b1, 1'b0, 0);
        chk(done_cnt == 1 && last_stat == 2'd0, "R5 good frame", last_stat, 0);
        check_bytes(n, "R4 bytes/sof");
        chk(done_cnt == 1, "R1 sync after garbage", done_cnt, 1);
      end
    end
    gap = 0;

    // R3: every-ones payload needs stuffing
    for (int i = 0; i < 4; i++) fb[i] = 8'hFF;
    clear_mon(); send_frame(4, 1'b1, 1'b0, 0);
    chk(last_stat == 2'd0 && done_cnt == 1, "R3 stuffed ones", last_stat, 0);
    check_bytes(4, "R3 stuffed data");

    // R5: corrupted check sequence, non-octet length
    fb[0] = 8'h12; fb[1] = 8'h34; fb[2] = 8'h56;
    clear_mon(); send_frame(3, 1'b1, 1'b1, 0);
    chk(done_cnt == 1 && last_stat == 2'd1, "R5 bad fcs", last_stat, 1);
    clear_mon(); send_frame(3, 1'b1, 1'b0, 3);
    chk(done_cnt == 1 && last_stat == 2'd1, "R5 non-octet", last_stat, 1);

    // R6: too short
    clear_mon(); send_frame(1, 1'b1, 1'b0, 0);
    chk(done_cnt == 1 && last_stat == 2'd3, "R6 three bytes", last_stat, 3);
    clear_mon(); send_frame(0, 1'b1, 1'b0, 0);
    chk(done_cnt == 1 && last_stat == 2'd3, "R6 two bytes", last_stat, 3);
    clear_mon(); put_flag(); put_data(1'b1); put_data(1'b0); put_data(1'b1); put_flag(); idle(4);
    chk(done_cnt == 1 && last_stat == 2'd3, "R6 three bits", last_stat, 3);

    // R7: address filter
    addr_en = 1'b1; addr_val = 8'h5A;
    fb[0] = 8'h5A; fb[1] = 8'h01; fb[2] = 8'h02;
    clear_mon(); send_frame(3, 1'b1, 1'b0, 0);
    chk(done_cnt == 1 && last_stat == 2'd0, "R7 match", last_stat, 0);
    check_bytes(3, "R7 match bytes");
    fb[0] = 8'h33;
    clear_mon(); send_frame(3, 1'b1, 1'b0, 0);
    chk(done_cnt == 0 && got_q.size() == 0, "R7 mismatch dropped", done_cnt + got_q.size(), 0);
    addr_en = 1'b0;
    clear_mon(); send_frame(3, 1'b1, 1'b0, 0);
    chk(done_cnt == 1 && got_q.size() == 3, "R7 filter off", got_q.size(), 3);

    // R8: abort mid-frame, then recovery
    clear_mon(); put_flag(); put_byte(8'h12); put_byte(8'h34); put_ones(8); idle(4);
    chk(done_cnt == 1 && last_stat == 2'd2, "R8 abort", last_stat, 2);
    clear_mon(); put_flag(); put_ones(8); idle(4);
    chk(done_cnt == 0, "R8 ones after flag", done_cnt, 0);
    fb[0] = 8'hC3; fb[1] = 8'h3C; fb[2] = 8'h7E;
    clear_mon(); put_ones(8); send_frame(3, 1'b1, 1'b0, 0);
    chk(done_cnt == 1 && last_stat == 2'd0, "R8 resync after abort", last_stat, 0);

    // R9: go-ahead
    clear_mon(); put_flag(); put_flag(); idle(4);
    chk(ga_cnt == 0, "R9 flags only", ga_cnt, 0);
    clear_mon(); put_flag(); put_ones(7); put_raw(1'b0); idle(4);
    chk(ga_cnt == 1, "R9 go-ahead", ga_cnt, 1);
    chk(done_cnt == 0, "R9 no frame", done_cnt, 0);

    // R2: repeated and shared flags
    fb[0] = 8'hA1; fb[1] = 8'hB2; fb[2] = 8'hC3;
    clear_mon(); put_flag(); put_flag(); put_flag();
    send_frame(3, 1'b0, 1'b0, 0);
    send_frame(3, 1'b0, 1'b0, 0);
    put_flag(); put_flag(); idle(4);
    chk(done_cnt == 2 && last_stat == 2'd0, "R2 shared flags", done_cnt, 2);
    chk(got_q.size() == 6, "R2 no flag bytes", got_q.size(), 6);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule